// File: doc/BRIEF.md
# Eight-Bit Operation-Select ALU

This block is a purely combinational arithmetic logic unit. It accepts two unsigned operands and a 3-bit operation code, and it drives one result of the same width. The operation code chooses one of eight functions:

- a constant all-zeros or all-ones word,
- a bitwise AND, OR or XOR of the operands,
- the inverse of the first operand,
- an unsigned sum or an unsigned difference.

The sum and the difference wrap modulo 2^WIDTH. The carry out and the borrow are dropped, and the block reports no flags.

Internally the block has four parts. A decoder turns the code into a one-hot set of lane enables. A bitwise unit produces all logic results in parallel. A single ripple adder serves both addition and subtraction: for subtraction it inverts the second operand and feeds a carry-in of one. An AND-OR merge picks the enabled lane. There are no registers, so the block has no state machine. A new result is visible as soon as the inputs settle. The block is used wherever a small datapath needs a code-selected operation with no cycle of latency.

Top module: `alu8`

## Requirements
- R1: With code 3'b000, `y_o` is all zeros whatever the operands are.
- R2: With code 3'b111, `y_o` is all ones (8'hFF at the default width) whatever the operands are.
- R3: With code 3'b001, `y_o` is the bitwise AND of `a_i` and `b_i`.
- R4: With code 3'b010, `y_o` is the bitwise OR of `a_i` and `b_i`.
- R5: With code 3'b011, `y_o` is the bitwise XOR of `a_i` and `b_i`.
- R6: With code 3'b100, `y_o` is the bitwise inverse of `a_i`, and `b_i` has no effect on the result.
- R7: With code 3'b101, `y_o` is `a_i` minus `b_i` modulo 256, with the borrow discarded. For example, 8'h00 minus 8'h01 gives 8'hFF.
- R8: With code 3'b110, `y_o` is `a_i` plus `b_i` modulo 256, with the carry discarded. For example, 8'hFF plus 8'h01 gives 8'h00.
- R9: When every input bit is 0 or 1, every bit of `y_o` is 0 or 1. No X or Z reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | 3 | Operation code |
| a_i | input | WIDTH (8) | First unsigned operand |
| b_i | input | WIDTH (8) | Second unsigned operand |
| y_o | output | WIDTH (8) | Result of the selected operation |

## Verification
The bound checker re-derives the expected result for whichever code is present whenever the inputs change. It uses plain behavioural arithmetic on widened operands, not the shared ripple adder, so it checks R1 to R8 and the absence of unknowns for R9 on every input change. What only the bench's scenarios can show is coverage:

- each code under the operand pairs 00/00, FF/FF, 00/FF and FF/00,
- equal operands, and a first operand smaller than the second, for subtraction,
- a long random sweep.

The R6 claim that the second operand is ignored is also a bench scenario: the first operand is held while the second changes, and the output must stay the same.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        OP_CLEAR = 3'b000,
        OP_AND   = 3'b001,
        OP_OR    = 3'b010,
        OP_XOR   = 3'b011,
        OP_INV   = 3'b100,
        OP_SUB   = 3'b101,
        OP_ADD   = 3'b110,
        OP_SET   = 3'b111
    } op_e;

    typedef struct packed {
        logic clear;
        logic land;
        logic lor;
        logic lxor;
        logic inv;
        logic sub;
        logic add;
        logic set;
    } lane_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output lane_t             lane_o
);

    always_comb begin
        lane_o = '0;
        unique case (op_e'(code_i))
            OP_CLEAR: lane_o.clear = 1'b1;
            OP_AND:   lane_o.land  = 1'b1;
            OP_OR:    lane_o.lor   = 1'b1;
            OP_XOR:   lane_o.lxor  = 1'b1;
            OP_INV:   lane_o.inv   = 1'b1;
            OP_SUB:   lane_o.sub   = 1'b1;
            OP_ADD:   lane_o.add   = 1'b1;
            OP_SET:   lane_o.set   = 1'b1;
            default:  lane_o       = '0;
        endcase
    end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] xor_o,
    output logic [WIDTH-1:0] inv_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign and_o[i] = a_i[i] & b_i[i];
        assign or_o[i]  = a_i[i] | b_i[i];
        assign xor_o[i] = a_i[i] ^ b_i[i];
        assign inv_o[i] = ~a_i[i];
    end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o
);

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] b_eff;

    // Subtraction adds the inverted operand plus one; the top carry is dropped.
    assign carry[0] = sub_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign b_eff[i]   = b_i[i] ^ sub_i;
        assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
    end

endmodule

// File: rtl/alu8.sv
module alu8
    import alu8_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [CODE_W-1:0] sel_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    output logic [WIDTH-1:0]  y_o
);

    lane_t            lane;
    logic [WIDTH-1:0] and_v;
    logic [WIDTH-1:0] or_v;
    logic [WIDTH-1:0] xor_v;
    logic [WIDTH-1:0] inv_v;
    logic [WIDTH-1:0] arith_v;

    alu8_decode u_decode (
        .code_i (sel_i),
        .lane_o (lane)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i   (a_i),
        .b_i   (b_i),
        .and_o (and_v),
        .or_o  (or_v),
        .xor_o (xor_v),
        .inv_o (inv_v)
    );

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (lane.sub),
        .sum_o (arith_v)
    );

    // One-hot AND-OR merge; the clear lane contributes nothing.
    always_comb begin
        y_o = '0;
        y_o = y_o | ({WIDTH{lane.land}}            & and_v);
        y_o = y_o | ({WIDTH{lane.lor}}             & or_v);
        y_o = y_o | ({WIDTH{lane.lxor}}            & xor_v);
        y_o = y_o | ({WIDTH{lane.inv}}             & inv_v);
        y_o = y_o | ({WIDTH{lane.sub | lane.add}}  & arith_v);
        y_o = y_o | ({WIDTH{lane.set}});
    end

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic [2:0]       sel_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] y_o
);

    logic [WIDTH:0] wide_sum;
    logic [WIDTH:0] wide_dif;
    logic           known_in;

    assign wide_sum = {1'b0, a_i} + {1'b0, b_i};
    assign wide_dif = {1'b0, a_i} - {1'b0, b_i};
    assign known_in = !$isunknown({sel_i, a_i, b_i});

    always_comb begin
        if (known_in) begin
            AST_NO_UNKNOWN: assert (!$isunknown(y_o));                          // R9
            if (sel_i == 3'b000) AST_CLEAR: assert (y_o == '0);                 // R1
            if (sel_i == 3'b111) AST_SET:   assert (y_o == '1);                 // R2
            if (sel_i == 3'b001) AST_AND:   assert (y_o == (a_i & b_i));        // R3
            if (sel_i == 3'b010) AST_OR:    assert (y_o == (a_i | b_i));        // R4
            if (sel_i == 3'b011) AST_XOR:   assert (y_o == (a_i ^ b_i));        // R5
            if (sel_i == 3'b100) AST_INV:   assert ((y_o ^ a_i) == '1);         // R6
            if (sel_i == 3'b101) AST_SUB_WRAP: assert (y_o == wide_dif[WIDTH-1:0]); // R7
            if (sel_i == 3'b110) AST_ADD_WRAP: assert (y_o == wide_sum[WIDTH-1:0]); // R8
        end
    end

endmodule

bind alu8 alu8_chk #(.WIDTH(WIDTH)) u_chk (
    .sel_i (sel_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .y_o   (y_o)
);

// File: tb/alu8_tb_top.sv
module alu8_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic [2:0] sel = '0;
    logic [7:0] a   = '0;
    logic [7:0] b   = '0;
    logic [7:0] y;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8 dut_i (
        .sel_i (sel),
        .a_i   (a),
        .b_i   (b),
        .y_o   (y)
    );

    function automatic int model(input int code, input int x, input int z);
        case (code)
            0: return 0;
            1: return x & z;
            2: return x | z;
            3: return x ^ z;
            4: return 255 - x;
            5: return (x - z + 256) % 256;
            6: return (x + z) % 256;
            default: return 255;
        endcase
    endfunction

    function automatic string tag(input int code);
        case (code)
            0: return "R1";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic apply(input int code, input int x, input int z);
        int exp;
        @(posedge clk);
        sel <= 3'(code);
        a   <= 8'(x);
        b   <= 8'(z);
        @(negedge clk);
        exp = model(code, x, z);
        n_run++;
        if ($isunknown(y)) begin
            n_fail++;
            $display("FAIL R9 sel=%0d a=%02h b=%02h actual=%b expected=known", code, x, z, y);
        end else if (int'(y) != exp) begin
            n_fail++;
            $display("FAIL %s sel=%0d a=%02h b=%02h actual=%02h expected=%02h",
                     tag(code), code, x, z, y, exp);
        end
    endtask

    initial begin
        int held;
        // first check: all inputs at zero (R1)
        apply(0, 8'h00, 8'h00);
        for (int c = 0; c < 8; c++) begin
            apply(c, 8'h00, 8'h00);
            apply(c, 8'hFF, 8'hFF);
            apply(c, 8'h00, 8'hFF);
            apply(c, 8'hFF, 8'h00);
            apply(c, 8'h5A, 8'h5A);
            apply(c, 8'h12, 8'hC4);
        end
        // R8 carry dropped, R7 borrow dropped
        apply(6, 8'hFF, 8'h01);
        apply(5, 8'h00, 8'h01);
        apply(5, 8'h80, 8'h80);
        // R6: b varies, a held, output must not move
        for (int k = 0; k < 16; k++) begin
            held = 8'h3C;
            apply(4, held, k * 17);
        end
        // random sweep over every code
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 300; r++) begin
                apply(c, int'($urandom_range(255)), int'($urandom_range(255)));
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule